// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache with Narrow Burst Line Fill

This block sits between an instruction fetch unit and a narrow external memory port. It holds 8 KB of instructions as 512 lines of 16 bytes, looked up by physical address. Each line has one tag and one valid bit. A fetch that hits returns its 32-bit word in the same clock cycle in which the request is presented. A fetch that misses starts a burst read of the whole line from the line-aligned address. The burst runs over a port that is 16 bits or 8 bits wide, chosen at run time. When the last beat arrives, the line is stored and marked valid, and the requested word is returned on the next cycle.

The fetch unit raises `fetch_req` with a word address and holds both until `fetch_ready` is seen high. Only one fetch is in flight at a time, so a fetch made while a fill is running waits until that fill completes. `inval_all` clears every valid bit in one cycle.

The controller has three states. `ST_IDLE` looks up each request. On a hit it answers at once and stays in `ST_IDLE`; on a miss it moves to `ST_FILL`. `ST_FILL` holds the burst request and gathers beats; on the final beat it moves to `ST_RESPOND`. `ST_RESPOND` returns the requested word for one cycle and always moves back to `ST_IDLE`.

Top module: `icache_burst_fill`

## Requirements
- R1: After reset every line is invalid, `fetch_ready` and `mem_req` are low, and the first fetch to any address misses.
- R2: A fetch to a valid line with a matching tag raises `fetch_ready` in the same cycle as `fetch_req`, with `mem_req` low. `fetch_data` holds the four bytes starting at the word-aligned address, with the lowest-addressed byte in bits [7:0].
- R3: On a miss, `mem_req` rises on the next cycle. `mem_addr` equals the fetch address with bits [3:0] cleared and stays stable while `mem_req` is high. `mem_req` falls on the edge that accepts the final beat.
- R4: With `port_narrow`=0 (16-bit port) a fill takes exactly 8 beats. Beat k carries line bytes 2k (bits [7:0]) and 2k+1 (bits [15:8]).
- R5: With `port_narrow`=1 (8-bit port) a fill takes exactly 16 beats. Beat k carries line byte k in bits [7:0]; bits [15:8] are ignored.
- R6: The cycle after the final beat, `fetch_ready` is high with the requested word. A later fetch to that line hits.
- R7: The line index is address bits [12:4] and the tag is bits [31:13]. A fetch with the same index but a different tag misses and replaces the line, so the old address misses again afterwards.
- R8: `inval_all` clears every valid bit at the next edge, so later fetches miss. If it coincides with a fill's final beat, the clear wins: the word is still returned, but the line stays invalid.
- R9: While a fill runs, `fetch_ready` stays low. `port_narrow` is sampled when the fill starts, and later changes to it do not affect the current fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_req | input | 1 | Fetch request, held until accepted |
| fetch_addr | input | 32 | Physical byte address of the instruction word |
| fetch_ready | output | 1 | Requested word is on `fetch_data` this cycle |
| fetch_data | output | 32 | Instruction word |
| port_narrow | input | 1 | External port width: 0 = 16 bits, 1 = 8 bits |
| inval_all | input | 1 | Clear all valid bits |
| mem_req | output | 1 | Burst read in progress |
| mem_addr | output | 32 | Line-aligned burst start address |
| mem_beat_valid | input | 1 | A beat is on `mem_beat_data` this cycle |
| mem_beat_data | input | 16 | Beat data |

## Verification
The assertions assume the fetch unit keeps `fetch_req` high and `fetch_addr` unchanged from raising a request until it sees `fetch_ready`. They also assume that memory drives `mem_beat_valid` only while `mem_req` is high. The bench's driver task holds each request until the ready cycle and drops it one edge later. Its memory model sends beats only after it sees `mem_req`, inserts gap cycles between beats, and stops after exactly the expected beat count. The bench drives `port_narrow` and `inval_all` at negative edges, so both change away from the sampling edge.

// File: rtl/icache_pkg.sv
`timescale 1ns/1ps
package icache_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_FILL    = 2'd1,
        ST_RESPOND = 2'd2
    } ic_state_e;

    localparam int WORD_W = 32;
    localparam int BEAT_W = 16;

    // picks 32-bit word number sel from a 128-bit line, little-endian byte order
    function automatic logic [WORD_W-1:0] pick_word(input logic [127:0] line,
                                                    input logic [1:0]   sel);
        logic [WORD_W-1:0] w;
        w = '0;
        for (int i = 0; i < 4; i++) begin
            if (sel == 2'(i)) w = line[i*WORD_W +: WORD_W];
        end
        return w;
    endfunction

endpackage

// File: rtl/icache_tag_store.sv
`timescale 1ns/1ps
module icache_tag_store #(
    parameter int LINES = 512,
    parameter int IDX_W = 9,
    parameter int TAG_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             hit,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             clr_all
);

    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_mem [LINES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (clr_all) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) tag_mem[wr_idx] <= wr_tag;
    end

    always_comb begin
        hit = valid_q[rd_idx] && (tag_mem[rd_idx] == rd_tag);
    end

    // R8: a clear leaves no line valid, even if a fill completes on the same edge
    assert_clear_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (valid_q == '0));

endmodule

// File: rtl/icache_data_store.sv
`timescale 1ns/1ps
module icache_data_store #(
    parameter int LINES  = 512,
    parameter int IDX_W  = 9,
    parameter int LINE_W = 128
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [LINE_W-1:0] wr_line,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [LINE_W-1:0] rd_line
);

    logic [LINE_W-1:0] line_mem [LINES];

    always_ff @(posedge clk) begin
        if (wr_en) line_mem[wr_idx] <= wr_line;
    end

    always_comb begin
        rd_line = line_mem[rd_idx];
    end

endmodule

// File: rtl/icache_beat_assembler.sv
`timescale 1ns/1ps
module icache_beat_assembler #(
    parameter int LINE_BYTES = 16,
    parameter int BEAT_W     = 16,
    parameter int CNT_W      = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    narrow_in,
    input  logic                    beat_valid,
    input  logic [BEAT_W-1:0]       beat_data,
    output logic                    last_beat,
    output logic [LINE_BYTES*8-1:0] line_next,
    output logic [LINE_BYTES*8-1:0] line_q
);

    localparam int LINE_W     = LINE_BYTES * 8;
    localparam int WIDE_BEATS = LINE_BYTES / 2;
    localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(LINE_BYTES - 1);
    localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(WIDE_BEATS - 1);

    logic             active_q;
    logic             narrow_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_idx;
    logic             take;

    always_comb begin
        last_idx  = narrow_q ? LAST_NARROW : LAST_WIDE;
        take      = active_q && beat_valid;
        last_beat = take && (cnt_q == last_idx);
    end

    // merge the beat on the bus into the partial line
    always_comb begin
        line_next = line_q;
        if (take) begin
            if (narrow_q) begin
                for (int b = 0; b < LINE_BYTES; b++) begin
                    if (cnt_q == CNT_W'(b)) line_next[b*8 +: 8] = beat_data[7:0];
                end
            end else begin
                for (int h = 0; h < WIDE_BEATS; h++) begin
                    if (cnt_q == CNT_W'(h)) line_next[h*16 +: 16] = beat_data[15:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            narrow_q <= 1'b0;
            cnt_q    <= '0;
            line_q   <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            narrow_q <= narrow_in;
            cnt_q    <= '0;
        end else if (take) begin
            line_q <= line_next;
            if (last_beat) begin
                active_q <= 1'b0;
                cnt_q    <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R4, R5: the beat counter never runs past the last beat of the latched width
    assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> (cnt_q <= last_idx));

    // R9: the width chosen at fill start holds until the fill ends
    assert_width_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !last_beat && !start) |=> $stable(narrow_q));

    initial begin
        assert (LINE_W == WIDE_BEATS * BEAT_W);
    end

endmodule

// File: rtl/icache_burst_fill.sv
`timescale 1ns/1ps
module icache_burst_fill
    import icache_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int NUM_LINES  = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_ready,
    output logic [WORD_W-1:0] fetch_data,
    input  logic              port_narrow,
    input  logic              inval_all,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_beat_valid,
    input  logic [BEAT_W-1:0] mem_beat_data
);

    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(NUM_LINES);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int LINE_W = LINE_BYTES * 8;
    localparam int CNT_W  = OFF_W;

    ic_state_e         state_q, state_d;
    logic [ADDR_W-1:0] req_addr_q;
    logic              hit;
    logic              fill_start;
    logic              last_beat;
    logic [LINE_W-1:0] rd_line;
    logic [LINE_W-1:0] fill_line_next;
    logic [LINE_W-1:0] fill_line_q;

    logic [IDX_W-1:0]  look_idx, fill_idx;
    logic [TAG_W-1:0]  look_tag, fill_tag;

    always_comb begin
        look_idx = fetch_addr[OFF_W +: IDX_W];
        look_tag = fetch_addr[ADDR_W-1 -: TAG_W];
        fill_idx = req_addr_q[OFF_W +: IDX_W];
        fill_tag = req_addr_q[ADDR_W-1 -: TAG_W];
    end

    icache_tag_store #(.LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (look_idx),
        .rd_tag  (look_tag),
        .hit     (hit),
        .wr_en   (last_beat),
        .wr_idx  (fill_idx),
        .wr_tag  (fill_tag),
        .clr_all (inval_all)
    );

    icache_data_store #(.LINES(NUM_LINES), .IDX_W(IDX_W), .LINE_W(LINE_W)) u_data (
        .clk     (clk),
        .wr_en   (last_beat),
        .wr_idx  (fill_idx),
        .wr_line (fill_line_next),
        .rd_idx  (look_idx),
        .rd_line (rd_line)
    );

    icache_beat_assembler #(.LINE_BYTES(LINE_BYTES), .BEAT_W(BEAT_W), .CNT_W(CNT_W)) u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (fill_start),
        .narrow_in  (port_narrow),
        .beat_valid (mem_beat_valid),
        .beat_data  (mem_beat_data),
        .last_beat  (last_beat),
        .line_next  (fill_line_next),
        .line_q     (fill_line_q)
    );

    // next-state logic
    always_comb begin
        state_d    = state_q;
        fill_start = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (fetch_req && !hit) begin
                    fill_start = 1'b1;
                    state_d    = ST_FILL;
                end
            end
            ST_FILL: begin
                if (last_beat) state_d = ST_RESPOND;
            end
            ST_RESPOND: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and captured miss address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            req_addr_q <= '0;
        end else begin
            state_q <= state_d;
            if (fill_start) req_addr_q <= fetch_addr;
        end
    end

    // outputs per state
    always_comb begin
        fetch_ready = 1'b0;
        fetch_data  = pick_word(rd_line, fetch_addr[3:2]);
        mem_req     = 1'b0;
        mem_addr    = {req_addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        unique case (state_q)
            ST_IDLE: begin
                fetch_ready = fetch_req && hit;
            end
            ST_FILL: begin
                mem_req = 1'b1;
            end
            ST_RESPOND: begin
                fetch_ready = 1'b1;
                fetch_data  = pick_word(fill_line_q, req_addr_q[3:2]);
            end
            default: ;
        endcase
    end

    // R2: input rule, a pending fetch keeps its request and address
    assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_ready) |=> (fetch_req && $stable(fetch_addr)));

    // R3: burst address holds for the whole burst
    assert_burst_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req)) |-> $stable(mem_addr));

    // R6: final beat is followed by the answer and the end of the burst
    assert_answer_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |=> (fetch_ready && !mem_req));

    // R9: no answer while the burst is running
    assert_stall_during_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !fetch_ready);

    // R3: a miss in idle opens a burst on the next cycle
    assert_miss_opens_burst_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && fetch_req && !fetch_ready) |=> mem_req);

endmodule

// File: tb/test_icache_burst_fill.sv
`timescale 1ns/1ps
module test_icache_burst_fill;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_req = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        fetch_ready;
    logic [31:0] fetch_data;
    logic        port_narrow = 1'b0;
    logic        inval_all = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_beat_valid = 1'b0;
    logic [15:0] mem_beat_data = '0;

    int checks = 0;
    int errors = 0;
    bit flip_mid = 1'b0;
    bit inval_last = 1'b0;
    logic [31:0] exp_line = '0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    icache_burst_fill i_icache_burst_fill (
        .clk(clk), .rst_n(rst_n),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_ready(fetch_ready), .fetch_data(fetch_data),
        .port_narrow(port_narrow), .inval_all(inval_all),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_beat_valid(mem_beat_valid), .mem_beat_data(mem_beat_data)
    );

    function automatic logic [7:0] mb(input logic [31:0] a);
        logic [7:0] s;
        s = (a[7:0] * 8'd29) ^ a[15:8] ^ (a[23:16] + 8'd3) ^ a[31:24];
        return s;
    endfunction

    function automatic logic [31:0] word_at(input logic [31:0] a);
        logic [31:0] al;
        al = {a[31:2], 2'b00};
        return {mb(al + 32'd3), mb(al + 32'd2), mb(al + 32'd1), mb(al)};
    endfunction

    task automatic chk(input bit ok, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && fetch_ready && fetch_req) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected answer", fetch_data, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(fetch_data == e, {t, " data"}, fetch_data, e);
            end
        end
    end

    // external memory model
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && mem_req) begin
                bit n;
                int nb;
                logic [31:0] base;
                n = port_narrow;
                nb = n ? 16 : 8;
                base = mem_addr;
                chk(base == exp_line, "R3 burst address", base, exp_line);
                for (int k = 0; k < nb; k++) begin
                    chk(mem_req, n ? "R5 burst still open" : "R4 burst still open",
                        32'(mem_req), 32'h1);
                    if (k % 3 == 2) begin
                        mem_beat_valid = 1'b0;
                        @(negedge clk);
                    end
                    if (flip_mid && k == 3) port_narrow = ~n;
                    mem_beat_valid = 1'b1;
                    if (n) mem_beat_data = {8'hC3, mb(base + 32'(k))};
                    else   mem_beat_data = {mb(base + 32'(2*k+1)), mb(base + 32'(2*k))};
                    if (k == nb - 1 && inval_last) inval_all = 1'b1;
                    @(negedge clk);
                end
                mem_beat_valid = 1'b0;
                inval_all = 1'b0;
                port_narrow = n;
                chk(!mem_req, "R3 burst closes after final beat", 32'(mem_req), 32'h0);
            end
        end
    end

    task automatic fetch(input logic [31:0] addr, input bit exp_hit, input string t);
        int n;
        exp_q.push_back(word_at(addr));
        tag_q.push_back(t);
        exp_line = {addr[31:4], 4'h0};
        @(posedge clk);
        #1;
        fetch_req = 1'b1;
        fetch_addr = addr;
        @(negedge clk);
        if (exp_hit)
            chk(fetch_ready && !mem_req, {t, " hit in same cycle"}, 32'(fetch_ready), 32'h1);
        else
            chk(!fetch_ready, {t, " miss expected"}, 32'(fetch_ready), 32'h0);
        n = 0;
        while (!fetch_ready && n < 200) begin
            @(negedge clk);
            if (mem_req && fetch_ready)
                chk(1'b0, "R9 ready during fill", 32'h1, 32'h0);
            n++;
        end
        chk(fetch_ready, {t, " completes"}, 32'(fetch_ready), 32'h1);
        @(posedge clk);
        #1;
        fetch_req = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!fetch_ready && !mem_req, "R1 outputs low after reset", {30'h0, fetch_ready, mem_req}, 32'h0);
        // R1/R4: cold miss over 16-bit port, then hits (R2, R6)
        port_narrow = 1'b0;
        fetch(32'h0000_1234, 1'b0, "R1 R4 cold miss");
        fetch(32'h0000_1234, 1'b1, "R6 refetch hits");
        for (int w = 0; w < 4; w++)
            fetch(32'h0000_1230 + 32'(4*w), 1'b1, "R2 word select");
        // R5: 8-bit port fill
        @(negedge clk); port_narrow = 1'b1;
        fetch(32'h0004_0A58, 1'b0, "R5 narrow fill");
        fetch(32'h0004_0A54, 1'b1, "R5 narrow line hit");
        // R7: same index, different tag
        @(negedge clk); port_narrow = 1'b0;
        fetch(32'h0000_3234, 1'b0, "R7 conflict miss");
        fetch(32'h0000_1234, 1'b0, "R7 evicted line misses");
        fetch(32'h0000_1238, 1'b1, "R7 refilled line hits");
        // R8: clear in idle
        @(negedge clk); inval_all = 1'b1;
        @(negedge clk); inval_all = 1'b0;
        fetch(32'h0004_0A58, 1'b0, "R8 miss after clear");
        // R9: width change mid-fill ignored
        flip_mid = 1'b1;
        fetch(32'h00AB_CDE0, 1'b0, "R9 width held");
        flip_mid = 1'b0;
        fetch(32'h00AB_CDEC, 1'b1, "R9 line intact");
        @(negedge clk); port_narrow = 1'b1;
        flip_mid = 1'b1;
        fetch(32'h0123_4560, 1'b0, "R9 narrow width held");
        flip_mid = 1'b0;
        fetch(32'h0123_4568, 1'b1, "R9 narrow line intact");
        // R8: clear on the final beat wins
        inval_last = 1'b1;
        fetch(32'h0000_7770, 1'b0, "R8 clear on last beat");
        inval_last = 1'b0;
        fetch(32'h0000_7770, 1'b0, "R8 line left invalid");
        // R7: top tag bits
        @(negedge clk); port_narrow = 1'b0;
        fetch(32'hFFFF_FFFC, 1'b0, "R7 top address miss");
        fetch(32'hFFFF_FFF0, 1'b1, "R7 top address hit");
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all answers seen", 32'(exp_q.size()), 32'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule